// File: doc/BRIEF.md
# PTP Local Time-of-Day Counter

This block keeps the local time of day for a precision-time receiver. The time has three fields: a 48-bit seconds count, a 30-bit nanoseconds count, and a 24-bit fraction of a nanosecond. All of it runs on the PTP clock. On every rising edge the block adds an increment to the nanosecond and fraction fields. The increment is measured in units of 2^-24 ns. Its nominal value comes from the clock-frequency parameter. For example, a 100446545 Hz clock gives roughly 9.955 ns per edge. When the nanosecond field reaches one second, the block carries into the seconds field.

An external frequency-correction loop controls the counter through an enable and a host-timestamp strobe.
- The first strobe after the enable rises copies the host time into the counter, once.
- Every later strobe leaves the time alone. It only latches a signed correction, which is added to the nominal increment from then on.
- Dropping the enable re-arms the one-time load and clears the correction.

A separate event strobe takes a snapshot of the full time value as it stood in the cycle the strobe was high.

The PTP clock may lie anywhere between 95 and 105 MHz. It need not be related to the host-interface clock. Any crossing between the two clocks is done outside this block.

Top module: `ptp_time_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first clock edge, all time outputs, all event outputs, `time_set` and `evt_valid` are zero.
- R2: On each rising edge, {`time_ns`,`time_frac`} grows by the effective increment. The unit is 2^-24 ns, and `time_frac` holds the low 24 bits. The nominal increment is floor(1e9 * 2^24 / CLK_FREQ_HZ). The effective increment equals the nominal increment while no correction is latched, and this includes the time when `adj_en` is low.
- R3: When the sum reaches or passes 1,000,000,000 ns, 1e9 ns is taken off and `time_sec` grows by one, modulo 2^48. `time_ns` always stays below 1e9.
- R4: If `sync_valid` and `adj_en` are high while `time_set` is 0, the next edge does four things:
  - loads `time_sec`/`time_ns` from `sync_sec`/`sync_ns`;
  - clears `time_frac`;
  - sets `time_set`;
  - resumes counting from the loaded value on the edges that follow.
- R5: If `sync_valid` and `adj_en` are high while `time_set` is 1, the time is not reloaded. Instead, the signed two's-complement `incr_adj` (unit 2^-24 ns) is latched. From the following edge on, the effective increment is the nominal increment plus that value.
- R6: A sum of nominal increment and correction below zero is clamped to zero, so the time holds still.
- R7: While `adj_en` is low, `sync_valid` is ignored. The next edge clears both `time_set` and the latched correction, so the next strobe with `adj_en` high loads again.
- R8: A high `evt_strobe` makes the next edge show, on `evt_sec`/`evt_ns`/`evt_frac`, the time that was on the time outputs during the strobe cycle, with `evt_valid` high for one cycle. Without a strobe the event outputs hold and `evt_valid` is low.
- R9: If an event strobe and a load fall in the same cycle, the snapshot holds the time from before the load, and the time outputs show the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adj_en | input | 1 | Frequency-adjustment enable |
| sync_valid | input | 1 | Host timestamp / correction strobe |
| sync_sec | input | 48 | Host timestamp seconds |
| sync_ns | input | 30 | Host timestamp nanoseconds (below 1e9) |
| incr_adj | input | 32 | Signed increment correction, 2^-24 ns units |
| evt_strobe | input | 1 | Event to be timestamped |
| time_sec | output | 48 | Current seconds |
| time_ns | output | 30 | Current nanoseconds |
| time_frac | output | 24 | Current fractional nanoseconds |
| time_set | output | 1 | Host time has been loaded since enable |
| evt_valid | output | 1 | Event snapshot updated this cycle |
| evt_sec | output | 48 | Snapshot seconds |
| evt_ns | output | 30 | Snapshot nanoseconds |
| evt_frac | output | 24 | Snapshot fractional nanoseconds |

## Verification
An event strobe can land in the same cycle as a one-time load of the host time. The bench provokes this by raising `evt_strobe`, `adj_en` and `sync_valid` together while `time_set` is clear. It then judges that the snapshot equals the time read just before that edge, and that the time outputs show the host value with a zero fraction. A correction strobe can also coincide with a seconds rollover. The table vectors place loads just below a second boundary and check the carried seconds against a closed-form sum of the nominal and corrected increments.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

    localparam longint unsigned NS_PER_SEC = 64'd1000000000;

    // Period of the clock in units of 2^-frac_w ns, rounded down.
    function automatic longint unsigned nominal_increment(
        input longint unsigned freq_hz,
        input int unsigned     frac_w
    );
        return (NS_PER_SEC << frac_w) / freq_hz;
    endfunction

    // What a host-timestamp strobe does in the current cycle.
    typedef enum logic [1:0] {
        SYNC_IGNORE = 2'd0,
        SYNC_LOAD   = 2'd1,
        SYNC_TUNE   = 2'd2
    } sync_action_e;

endpackage

// File: rtl/ptp_incr_ctrl.sv
// Decides between one-time load and increment tuning; owns the correction.
module ptp_incr_ctrl
    import ptp_time_pkg::*;
#(
    parameter int                INC_W   = 32,
    parameter int                ADJ_W   = 32,
    parameter logic [INC_W-1:0]  NOM_INC = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adj_en,
    input  logic                    sync_valid,
    input  logic signed [ADJ_W-1:0] incr_adj,
    output logic                    load_now,
    output logic                    time_set,
    output logic [INC_W-1:0]        eff_inc
);

    localparam int SUM_W = ((INC_W > ADJ_W) ? INC_W : ADJ_W) + 2;
    localparam logic signed [SUM_W-1:0] INC_MAX =
        $signed({{(SUM_W-INC_W){1'b0}}, {INC_W{1'b1}}});

    typedef struct packed {
        logic                    set;
        logic signed [ADJ_W-1:0] adj;
    } ctrl_t;

    ctrl_t                   ctrl_d, ctrl_q;
    sync_action_e            action;
    logic signed [SUM_W-1:0] inc_sum;
    logic [INC_W-1:0]        inc_d;

    always_comb begin
        action = SYNC_IGNORE;
        if (sync_valid && adj_en) begin
            action = ctrl_q.set ? SYNC_TUNE : SYNC_LOAD;
        end

        ctrl_d = ctrl_q;
        case (action)
            SYNC_LOAD: ctrl_d.set = 1'b1;
            SYNC_TUNE: ctrl_d.adj = incr_adj;
            default:   ctrl_d = ctrl_q;
        endcase
        if (!adj_en) begin
            ctrl_d.set = 1'b0;
            ctrl_d.adj = '0;
        end

        inc_sum = $signed({{(SUM_W-INC_W){1'b0}}, NOM_INC}) + SUM_W'(ctrl_q.adj);
        if (inc_sum < 0) begin
            inc_d = '0;
        end else if (inc_sum > INC_MAX) begin
            inc_d = '1;
        end else begin
            inc_d = inc_sum[INC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_now = (action == SYNC_LOAD);
    assign time_set = ctrl_q.set;
    assign eff_inc  = inc_d;

endmodule

// File: rtl/ptp_time_accum.sv
// Seconds / nanoseconds / fraction register with one-second carry and load.
module ptp_time_accum
    import ptp_time_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int FRAC_W = 24,
    parameter int INC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [NS_W-1:0]   load_ns,
    input  logic [INC_W-1:0]  inc,
    output logic [SEC_W-1:0]  sec,
    output logic [NS_W-1:0]   ns,
    output logic [FRAC_W-1:0] frac
);

    localparam int SUB_W = NS_W + FRAC_W;
    localparam int SUM_W = SUB_W + 1;
    localparam logic [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC << FRAC_W);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } acc_t;

    acc_t             acc_d, acc_q;
    logic [SUM_W-1:0] sub_sum;

    always_comb begin
        acc_d   = acc_q;
        sub_sum = {1'b0, acc_q.sub} + SUM_W'(inc);
        if (sub_sum >= ONE_SEC) begin
            acc_d.sub = SUB_W'(sub_sum - ONE_SEC);
            acc_d.sec = acc_q.sec + SEC_W'(1);
        end else begin
            acc_d.sub = sub_sum[SUB_W-1:0];
        end
        if (load) begin
            acc_d.sec = load_sec;
            acc_d.sub = {load_ns, {FRAC_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sec  = acc_q.sec;
    assign ns   = acc_q.sub[SUB_W-1:FRAC_W];
    assign frac = acc_q.sub[FRAC_W-1:0];

endmodule

// File: rtl/ptp_event_capture.sv
// Snapshot of the time vector taken on an event strobe.
module ptp_event_capture #(
    parameter int TIME_W = 102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [TIME_W-1:0] time_in,
    output logic              cap_valid,
    output logic [TIME_W-1:0] cap_time
);

    typedef struct packed {
        logic              valid;
        logic [TIME_W-1:0] stamp;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = strobe;
        if (strobe) begin
            cap_d.stamp = time_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_valid = cap_q.valid;
    assign cap_time  = cap_q.stamp;

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_time_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 100446545,
    parameter int              SEC_W       = 48,
    parameter int              NS_W        = 30,
    parameter int              FRAC_W      = 24,
    parameter int              INC_W       = 32,
    parameter int              ADJ_W       = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adj_en,
    input  logic                    sync_valid,
    input  logic [SEC_W-1:0]        sync_sec,
    input  logic [NS_W-1:0]         sync_ns,
    input  logic signed [ADJ_W-1:0] incr_adj,
    input  logic                    evt_strobe,
    output logic [SEC_W-1:0]        time_sec,
    output logic [NS_W-1:0]         time_ns,
    output logic [FRAC_W-1:0]       time_frac,
    output logic                    time_set,
    output logic                    evt_valid,
    output logic [SEC_W-1:0]        evt_sec,
    output logic [NS_W-1:0]         evt_ns,
    output logic [FRAC_W-1:0]       evt_frac
);

    localparam int TIME_W = SEC_W + NS_W + FRAC_W;
    localparam logic [INC_W-1:0] NOM_INC =
        INC_W'(nominal_increment(CLK_FREQ_HZ, FRAC_W));

    logic              load_now;
    logic [INC_W-1:0]  eff_inc;
    logic [TIME_W-1:0] cap_time;

    ptp_incr_ctrl #(
        .INC_W   (INC_W),
        .ADJ_W   (ADJ_W),
        .NOM_INC (NOM_INC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .adj_en     (adj_en),
        .sync_valid (sync_valid),
        .incr_adj   (incr_adj),
        .load_now   (load_now),
        .time_set   (time_set),
        .eff_inc    (eff_inc)
    );

    ptp_time_accum #(
        .SEC_W  (SEC_W),
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .INC_W  (INC_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_now),
        .load_sec (sync_sec),
        .load_ns  (sync_ns),
        .inc      (eff_inc),
        .sec      (time_sec),
        .ns       (time_ns),
        .frac     (time_frac)
    );

    ptp_event_capture #(
        .TIME_W (TIME_W)
    ) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (evt_strobe),
        .time_in   ({time_sec, time_ns, time_frac}),
        .cap_valid (evt_valid),
        .cap_time  (cap_time)
    );

    assign {evt_sec, evt_ns, evt_frac} = cap_time;

endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
    import ptp_time_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int FRAC_W = 24,
    parameter int ADJ_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    adj_en,
    input logic                    sync_valid,
    input logic [SEC_W-1:0]        sync_sec,
    input logic [NS_W-1:0]         sync_ns,
    input logic signed [ADJ_W-1:0] incr_adj,
    input logic                    evt_strobe,
    input logic [SEC_W-1:0]        time_sec,
    input logic [NS_W-1:0]         time_ns,
    input logic [FRAC_W-1:0]       time_frac,
    input logic                    time_set,
    input logic                    evt_valid,
    input logic [SEC_W-1:0]        evt_sec,
    input logic [NS_W-1:0]         evt_ns,
    input logic [FRAC_W-1:0]       evt_frac
);

    localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);

    AST_NS_BELOW_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        time_ns < NS_LIMIT); // R3

    AST_TIME_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_valid && adj_en && !time_set)
        |=> {time_sec, time_ns, time_frac} >= $past({time_sec, time_ns, time_frac})); // R2

    AST_FIRST_SYNC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_valid && adj_en && !time_set)
        |=> time_set && time_sec == $past(sync_sec) && time_ns == $past(sync_ns)
            && time_frac == '0); // R4

    AST_DISABLE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_en |=> !time_set); // R7

    AST_EVENT_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |=> evt_valid && evt_sec == $past(time_sec)
            && evt_ns == $past(time_ns) && evt_frac == $past(time_frac)); // R8

    AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_strobe |=> !evt_valid && $stable({evt_sec, evt_ns, evt_frac})); // R8

endmodule

bind ptp_time_counter ptp_time_counter_chk #(
    .SEC_W  (SEC_W),
    .NS_W   (NS_W),
    .FRAC_W (FRAC_W),
    .ADJ_W  (ADJ_W)
) u_chk (.*);

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;

    localparam longint FREQ = 100446545;
    localparam longint ONE  = 64'sd1000000000 <<< 24;
    localparam longint NOM  = ONE / FREQ;

    typedef struct packed {
        logic [47:0]        sec;
        logic [29:0]        ns;
        logic signed [31:0] adj;
        logic [15:0]        k;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{48'd0,            30'd0,         32'sd0,            16'd10},
        '{48'd5,            30'd999999990, 32'sd0,            16'd3},
        '{48'h0000FFFFFFFF, 30'd999999999, 32'sd1000,         16'd2},
        '{48'd7,            30'd123456789, 32'(-NOM - 5),     16'd6},
        '{48'd1,            30'd500,       -32'sd1000,        16'd20},
        '{48'd42,           30'd999998000, 32'sd16777216,     16'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adj_en = 1'b0;
    logic        sync_valid = 1'b0;
    logic [47:0] sync_sec = '0;
    logic [29:0] sync_ns = '0;
    logic signed [31:0] incr_adj = '0;
    logic        evt_strobe = 1'b0;
    logic [47:0] time_sec;
    logic [29:0] time_ns;
    logic [23:0] time_frac;
    logic        time_set;
    logic        evt_valid;
    logic [47:0] evt_sec;
    logic [29:0] evt_ns;
    logic [23:0] evt_frac;

    int tests = 0;
    int fails = 0;
    logic [101:0] snap;

    always #4 clk = ~clk;

    ptp_time_counter #(.CLK_FREQ_HZ(FREQ)) uut (.*);

    task automatic check(input string req, input logic [101:0] act, input logic [101:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load L, one edge at nominal rate, then k edges at nominal+adj (clamped at 0).
    function automatic logic [101:0] expect_time(longint sec0, longint ns0, longint adj, longint k);
        longint eff;
        longint total;
        eff = NOM + adj;
        if (eff < 0) eff = 0;
        total = (ns0 <<< 24) + NOM + k * eff;
        return {48'(sec0 + total / ONE), 30'((total % ONE) >>> 24), 24'(total % (64'sd1 <<< 24))};
    endfunction

    function automatic logic [101:0] now_time();
        return {time_sec, time_ns, time_frac};
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        adj_en = 1'b0; sync_valid = 1'b0;
        @(negedge clk);
        adj_en = 1'b1; sync_valid = 1'b1; sync_sec = v.sec; sync_ns = v.ns; incr_adj = '0;
        @(negedge clk);
        check($sformatf("R4 vec%0d load", idx), {time_set, now_time()}, {1'b1, v.sec, v.ns, 24'd0});
        sync_sec = ~v.sec; sync_ns = 30'd17; incr_adj = v.adj;
        @(negedge clk);
        sync_valid = 1'b0;
        repeat (int'(v.k)) @(negedge clk);
        check($sformatf("R2 R3 R5 R6 vec%0d count", idx), now_time(),
              expect_time(longint'(v.sec), longint'(v.ns), longint'(v.adj), longint'(v.k)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 time", now_time(), '0);
        check("R1 flags", {100'd0, time_set, evt_valid}, '0);
        check("R1 event", {evt_sec, evt_ns, evt_frac}, '0);
        rst_n = 1'b1;
        check("R1 after release", now_time(), '0);

        // R2/R7: free run at nominal, strobes ignored while disabled
        sync_valid = 1'b1; sync_sec = 48'd99; sync_ns = 30'd77;
        repeat (5) @(negedge clk);
        check("R2 nominal run", now_time(), {48'd0, 30'((5 * NOM) >>> 24), 24'((5 * NOM) % (64'sd1 <<< 24))});
        check("R7 sync ignored when disabled", {101'd0, time_set}, '0);
        sync_valid = 1'b0;

        // Table walk
        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i], i);
        end

        // R7: disabling clears the load flag
        @(negedge clk);
        adj_en = 1'b0;
        @(negedge clk);
        check("R7 flag cleared", {101'd0, time_set}, '0);

        // R8: event snapshot and hold
        snap = now_time();
        evt_strobe = 1'b1;
        @(negedge clk);
        evt_strobe = 1'b0;
        check("R8 snapshot", {evt_valid, evt_sec, evt_ns, evt_frac}, {1'b1, snap});
        @(negedge clk);
        check("R8 hold", {evt_valid, evt_sec, evt_ns, evt_frac}, {1'b0, snap});

        // R9: event coincides with load
        snap = now_time();
        adj_en = 1'b1; sync_valid = 1'b1; sync_sec = 48'd9; sync_ns = 30'd250; evt_strobe = 1'b1;
        @(negedge clk);
        sync_valid = 1'b0; evt_strobe = 1'b0;
        check("R9 pre-load snapshot", {evt_sec, evt_ns, evt_frac}, snap);
        check("R9 loaded time", now_time(), {48'd9, 30'd250, 24'd0});

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {time_set, evt_valid, now_time()}, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule